// File: doc/BRIEF.md
# Single-Phase Target Termination Controller

This controller decides how each bus transaction aimed at a single-phase bridge target ends. It follows the start of each frame and the master's ready signal. It also uses the length of the local cycle that the bridge is about to run. From these it picks one of three endings: a normal completion with target-ready, a disconnect-with-data when the master tries to burst, or a retry when a read would not finish inside the 16-clock completion budget. When the access goes ahead, it sends a one-clock start request to the local cycle generator. The generator reports back with a done pulse.

All bus-side inputs are active-high, so "asserted" reads as 1. A frame starts in the first clock where `frameIn` is sampled high after a clock where it was low. Clocks are numbered from that clock, which is clock 1. Clock k is the first clock after the frame start in which `irdyIn` is sampled high.

The read budget is checked at run time. The controller adds the clocks already spent in the frame to the clocks still needed: the two-clock reference offset, the programmed local length `readLen`, and the final ready clock. This gives the clock in which target-ready would appear, P = k + 3 + readLen.

Top module: `tgt_term_ctrl`

## Requirements
- R1: After reset, `trdyOut`, `stopOut` and `localStart` are 0, and they stay 0 while no frame starts, whatever `irdyIn` does.
- R2: In a transaction that is not retried, `localStart` is high for exactly one clock, in clock k+2.
- R3: For a read (`readIn`=1) with P = k+3+readLen greater than 16, `stopOut` rises in clock k+1 with `trdyOut` low, and `localStart` never pulses in that transaction.
- R4: When no retry is signalled, `trdyOut` is high for exactly one clock: the clock after `localDone` is sampled high. With a generator that answers readLen clocks after the start pulse, that is clock P.
- R5: A write (`readIn`=0) is never retried, whatever `readLen` is.
- R6: If `frameIn` is still high when the local cycle ends, `stopOut` is asserted together with `trdyOut` in the data clock. After that, `stopOut` stays high alone until `frameIn` is sampled low.
- R7: Once `stopOut` is high without `trdyOut`, it drops in the clock after the first clock in which `frameIn` is sampled low.
- R8: A frame that starts in the clock right after a completed last data phase, with no idle clock between, restarts the clock count at 1. Its budget does not include the earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameIn | input | 1 | Master frame asserted (1 = asserted) |
| irdyIn | input | 1 | Master ready asserted (1 = asserted) |
| readIn | input | 1 | 1 = read access, 0 = write access |
| readLen | input | LEN_W | Programmed local cycle length in clocks |
| localDone | input | 1 | One-clock pulse from the local cycle generator when it finishes |
| trdyOut | output | 1 | Target ready |
| stopOut | output | 1 | Target stop (retry or disconnect) |
| localStart | output | 1 | One-clock start request to the local cycle generator |

## Verification
Every output is decoded from registered state, so each result appears in a known clock:
- stop for a retry appears one clock after clock k;
- the start request appears two clocks after clock k;
- target-ready appears one clock after the done pulse;
- a stop that is being held is released one clock after frame is sampled low.

The bench drives each clock's inputs on the falling edge. At the same falling edge, before changing anything, it records the outputs that belong to that clock. It then compares the recorded clock numbers with k+1, k+2 and k+3+readLen, which it works out from the requirements.

// File: rtl/tgt_term_pkg.sv
package tgt_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REF,
    ST_LOCAL,
    ST_DATA,
    ST_TERM
  } termState_t;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } cntCtl_t;

endpackage

// File: rtl/tgt_term_dp.sv
module tgt_term_dp
  import tgt_term_pkg::*;
#(
  parameter int LIMIT   = 16,
  parameter int LEN_W   = 5,
  parameter int REF_GAP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameIn,
  input  logic [LEN_W-1:0] readLen,
  input  cntCtl_t          ctl,
  output logic             frameRise,
  output logic             overBudget
);

  localparam int CNT_W = $clog2(LIMIT + 1) + 1;
  localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             frameQ;
  logic [CNT_W-1:0] elapsed;
  logic [SUM_W-1:0] predicted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= 1'b0;
    end else begin
      frameQ <= frameIn;
    end
  end

  assign frameRise = frameIn && !frameQ;

  // clocks spent in the current frame, the start clock counting as one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (ctl.cntClear) begin
      elapsed <= CNT_W'(1);
    end else if (ctl.cntRun && elapsed != CNT_MAX) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // clock of the ready phase if the access were allowed to run
  assign predicted = SUM_W'(elapsed) + SUM_W'(readLen) + SUM_W'(REF_GAP + 2);
  assign overBudget = predicted > SUM_W'(LIMIT);

  a_r8_count_restart: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClear |=> (elapsed == CNT_W'(1)));

endmodule

// File: rtl/tgt_term_ctl.sv
module tgt_term_ctl
  import tgt_term_pkg::*;
#(
  parameter int REF_GAP = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameIn,
  input  logic    irdyIn,
  input  logic    readIn,
  input  logic    localDone,
  input  logic    frameRise,
  input  logic    overBudget,
  output logic    trdyOut,
  output logic    stopOut,
  output logic    localStart,
  output cntCtl_t ctl
);

  localparam int REF_W = $clog2(REF_GAP + 1);

  termState_t       state;
  termState_t       nextState;
  logic [REF_W-1:0] refCnt;
  logic             burstFlag;
  logic             refLast;

  assign refLast = (refCnt == REF_W'(REF_GAP));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (frameRise) nextState = ST_WAIT;
      ST_WAIT:  if (irdyIn) nextState = (readIn && overBudget) ? ST_TERM : ST_REF;
      ST_REF:   if (refLast) nextState = ST_LOCAL;
      ST_LOCAL: if (localDone) nextState = ST_DATA;
      ST_DATA:  if (irdyIn) nextState = frameIn ? ST_TERM : ST_IDLE;
      ST_TERM:  if (!frameIn) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      refCnt    <= '0;
      burstFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_WAIT) begin
        refCnt <= REF_W'(1);
      end else if (state == ST_REF && !refLast) begin
        refCnt <= refCnt + 1'b1;
      end
      if (state == ST_LOCAL && localDone) begin
        burstFlag <= frameIn;
      end
    end
  end

  assign ctl.cntClear = (state == ST_IDLE) && frameRise;
  assign ctl.cntRun   = (state != ST_IDLE);

  assign trdyOut    = (state == ST_DATA);
  assign stopOut    = (state == ST_TERM) || ((state == ST_DATA) && burstFlag);
  assign localStart = (state == ST_REF) && refLast;

  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    localStart |=> !localStart);

  a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trdyOut) |-> $past(localDone));

  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOut && irdyIn) |=> !trdyOut);

  a_r5_retry_only_read: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stopOut) && !trdyOut) |-> $past(readIn));

  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    (stopOut && !trdyOut && !frameIn) |=> !stopOut);

endmodule

// File: rtl/tgt_term_ctrl.sv
module tgt_term_ctrl
  import tgt_term_pkg::*;
#(
  parameter int LIMIT   = 16,
  parameter int LEN_W   = 5,
  parameter int REF_GAP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameIn,
  input  logic             irdyIn,
  input  logic             readIn,
  input  logic [LEN_W-1:0] readLen,
  input  logic             localDone,
  output logic             trdyOut,
  output logic             stopOut,
  output logic             localStart
);

  cntCtl_t ctl;
  logic    frameRise;
  logic    overBudget;

  tgt_term_dp #(
    .LIMIT  (LIMIT),
    .LEN_W  (LEN_W),
    .REF_GAP(REF_GAP)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameIn   (frameIn),
    .readLen   (readLen),
    .ctl       (ctl),
    .frameRise (frameRise),
    .overBudget(overBudget)
  );

  tgt_term_ctl #(
    .REF_GAP(REF_GAP)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameIn   (frameIn),
    .irdyIn    (irdyIn),
    .readIn    (readIn),
    .localDone (localDone),
    .frameRise (frameRise),
    .overBudget(overBudget),
    .trdyOut   (trdyOut),
    .stopOut   (stopOut),
    .localStart(localStart),
    .ctl       (ctl)
  );

endmodule

// File: tb/tgt_term_ctrl_tb_top.sv
`timescale 1ns/1ps
module tgt_term_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameIn = 1'b0;
  logic       irdyIn = 1'b0;
  logic       readIn = 1'b0;
  logic [4:0] readLen = '0;
  logic       localDone = 1'b0;
  logic       trdyOut, stopOut, localStart;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tgt_term_ctrl dut_i (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .irdyIn(irdyIn),
    .readIn(readIn), .readLen(readLen), .localDone(localDone),
    .trdyOut(trdyOut), .stopOut(stopOut), .localStart(localStart)
  );

  // vector table: clock of first ready, local length, read, burst, expected retry
  localparam int NV = 11;
  localparam int vK     [NV] = '{2, 2, 2, 4, 4, 2, 3, 2, 2, 5, 3};
  localparam int vLen   [NV] = '{3, 11, 12, 9, 10, 12, 2, 5, 20, 1, 14};
  localparam int vRd    [NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 0};
  localparam int vBurst [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1};
  localparam int vRetry [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 0};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleClk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameIn = 1'b0; irdyIn = 1'b0; localDone = 1'b0;
    end
  endtask

  // one transaction; master and local generator model, records clock numbers
  task automatic runTxn(input int k, input int len, input bit rd, input bit burst,
                        output int trdyClk, output int trdyCnt, output int stopClk,
                        output int stopCnt, output int startClk);
    int doneAt = -1;
    bit stopSeen = 1'b0;
    bit fin = 1'b0;
    trdyClk = 0; trdyCnt = 0; stopClk = 0; stopCnt = 0; startClk = 0;
    for (int n = 1; n <= 80 && !fin; n++) begin
      @(negedge clk);
      if (trdyOut) begin trdyCnt++; if (trdyClk == 0) trdyClk = n; end
      if (stopOut) begin stopCnt++; if (stopClk == 0) stopClk = n; end
      if (localStart) begin if (startClk == 0) startClk = n; doneAt = n + len; end
      readIn = rd;
      readLen = 5'(len);
      if (n < k) begin frameIn = 1'b1; irdyIn = 1'b0; end
      else if (stopSeen) begin frameIn = 1'b0; irdyIn = 1'b1; end
      else begin frameIn = burst; irdyIn = 1'b1; end
      localDone = (n == doneAt);
      if ((trdyOut || stopOut) && !frameIn) fin = 1'b1;
      if (stopOut) stopSeen = 1'b1;
    end
    chk("R4 transaction ended", int'(fin), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int tc, tn, sc, sn, st;
    int p, k, len;
    bit rt, bu;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and after reset, irdy wiggling without a frame
    chk("R1 trdy in reset", int'(trdyOut), 0);
    chk("R1 stop in reset", int'(stopOut), 0);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 quiet without frame", int'(trdyOut | stopOut | localStart), 0);
      irdyIn = i[0];
    end
    idleClk(2);

    // table walk
    for (int v = 0; v < NV; v++) begin
      k = vK[v]; len = vLen[v]; rt = vRetry[v][0]; bu = vBurst[v][0];
      p = k + 3 + len;
      runTxn(k, len, vRd[v][0], bu, tc, tn, sc, sn, st);
      chk(rt ? "R3 no ready on retry" : "R4 ready clock", tc, rt ? 0 : p);
      chk("R4 ready count", tn, rt ? 0 : 1);
      chk(rt ? "R3 no start on retry" : "R2 start clock", st, rt ? 0 : k + 2);
      chk(rt ? "R3 retry stop clock" : (bu ? "R6 disconnect stop clock" : "R5 no stop"),
          sc, rt ? k + 1 : (bu ? p : 0));
      chk(bu ? "R6 stop held until frame low" : "R7 stop count",
          sn, (rt || bu) ? (bu ? 2 : 1) : 0);
      idleClk(2);
    end

    // R8: back-to-back, long write then read at the budget edge with no idle clock
    runTxn(2, 12, 1'b0, 1'b0, tc, tn, sc, sn, st);
    chk("R5 long write completes", tc, 17);
    runTxn(2, 11, 1'b1, 1'b0, tc, tn, sc, sn, st);
    chk("R8 back-to-back read ready clock", tc, 16);
    chk("R8 back-to-back read not retried", sn, 0);
    // R8: back-to-back after a retry, next read must retry again on its own count
    runTxn(3, 11, 1'b1, 1'b0, tc, tn, sc, sn, st);
    chk("R3 late ready retried", sc, 4);
    runTxn(2, 3, 1'b1, 1'b0, tc, tn, sc, sn, st);
    chk("R8 read after retry ready clock", tc, 8);
    idleClk(3);
    chk("R1 quiet after traffic", int'(trdyOut | stopOut | localStart), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule